// File: doc/BRIEF.md
# Graphics RAM Write Masking Unit

This block sits on the write path of a 32-bit graphics memory model or controller. It takes commands that have already been decoded, together with the column address, the data bus and four byte-mask bits. From these it produces one write request per command for a simple storage array. A request names an aligned group of eight columns, selects which of those columns are written, and gives a per-bit enable and the data word.

Three masks are merged to form the bit enable:

- **Byte masks.** A mask bit that is high blocks its byte lane.
- **Persistent bit mask.** Each bank opened with the bit-mask variant of activate applies the mask register to every write until that bank is closed. A plain activate leaves the mask register out of the enable.
- **Column select.** On a normal write, one column of the aligned group is selected. On a block write, the low eight data bits pick any subset of the eight columns, and a colour register supplies the data.

Each bank is tracked by a small state machine with three states:

| State | Meaning |
|---|---|
| `BK_IDLE` | Bank closed |
| `BK_OPEN` | Row open, bit mask off |
| `BK_OPEN_WPB` | Row open, bit mask on |

The transitions are:

- `BK_IDLE` goes to `BK_OPEN` on a plain activate, or to `BK_OPEN_WPB` on a bit-mask activate.
- Either open state returns to `BK_IDLE` on any of these:
  - a precharge of that bank;
  - a precharge-all;
  - a write or block write to that bank that carries the auto-close request.

All other events leave the state unchanged. The mask register and the colour register are loaded from the data bus by a register-load command.

Top module: `gram_wmask_unit`

## Requirements
- R1: After reset every bank is in `BK_IDLE`, the mask register holds all ones and the colour register holds zero. Whenever `we_o` is low, `we_bank_o`, `we_col_o`, `col_en_o`, `bit_en_o` and `data_o` are all zero.
- R2: A write (`wr_i`) to an open bank produces `we_o`=1 one cycle later, with:
  - `we_bank_o` equal to the bank;
  - `we_col_o` equal to `col_i` with bits [2:0] cleared;
  - `col_en_o` one-hot at bit `col_i[2:0]`;
  - `data_o` equal to `dq_i`.
- R3: On writes and block writes, `dqm_i[k]`=1 clears `bit_en_o[8k+7:8k]`, and `dqm_i[k]`=0 leaves that lane to the other masks.
- R4: In a bank opened with `act_wpb_i`=0, the mask register has no effect on `bit_en_o`.
- R5: In a bank opened with `act_wpb_i`=1, `bit_en_o` is ANDed with the mask register on every write and block write until that bank is closed.
- R6: A register load (`ld_i`) copies `dq_i` into the mask register when `ld_sel_i`=0, or into the colour register when `ld_sel_i`=1. The command issued next already uses the new value.
- R7: A block write (`bw_i`) to an open bank produces, one cycle later:
  - `col_en_o` equal to `dq_i[7:0]`, where bit i enables column base+i;
  - `data_o` equal to the colour register;
  - `we_col_o` equal to `col_i` with bits [2:0] cleared, so those bits are ignored.
- R8: A precharge (`pre_i`) closes the bank on `bank_i`, and `pre_all_i` closes every bank. A closed bank loses its bit-mask state, and later writes to it produce `we_o`=0.
- R9: A write or block write with `auto_pre_i`=1 is still performed, and its bank is closed afterwards.
- R10: A write or block write to a closed bank produces no request. An activate to an open bank is ignored and keeps that bank's bit-mask state.
- R11: Bit-mask state is kept per bank. Opening or closing one bank does not change how writes to another bank are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Activate strobe |
| act_wpb_i | input | 1 | With `act_i`: 1 selects the bit-mask variant |
| pre_i | input | 1 | Precharge strobe for bank `bank_i` |
| pre_all_i | input | 1 | Precharge-all strobe |
| wr_i | input | 1 | Write strobe |
| bw_i | input | 1 | Block write strobe |
| auto_pre_i | input | 1 | With `wr_i` or `bw_i`: close the bank after this command |
| ld_i | input | 1 | Register load strobe |
| ld_sel_i | input | 1 | Load target: 0 mask register, 1 colour register |
| bank_i | input | BANK_W | Bank address |
| col_i | input | COL_W | Column address |
| dq_i | input | DATA_W | Data bus (write data, column pattern or register value) |
| dqm_i | input | DATA_W/8 | Byte masks, high blocks a lane |
| we_o | output | 1 | Write request valid |
| we_bank_o | output | BANK_W | Bank of the request |
| we_col_o | output | COL_W | Aligned base column of the eight-column group |
| col_en_o | output | BLK_COLS | Columns written within the group |
| bit_en_o | output | DATA_W | Per-bit write enable |
| data_o | output | DATA_W | Data to store |

## Verification
A bank left in the wrong state shows up on the next write to that bank:

- A bank wrongly left open issues a request that should not exist.
- A bank wrongly left closed drops a request that should be issued.
- A bank with the wrong bit-mask state shows as extra or missing cleared bits in `bit_en_o`.

Any of these is visible one cycle after that write. A stale mask or colour register appears in `bit_en_o` or `data_o` on the first masked write or block write after the load. Each write in the sequence is compared against a reference model, so a divergence is caught on the command that exposes it.

// File: rtl/gwm_pkg.sv
package gwm_pkg;
    typedef enum logic [1:0] {
        BK_IDLE     = 2'd0,
        BK_OPEN     = 2'd1,
        BK_OPEN_WPB = 2'd2
    } bank_state_e;
endpackage

// File: rtl/gwm_bank_fsm.sv
module gwm_bank_fsm
    import gwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic act_i,
    input  logic act_wpb_i,
    input  logic pre_i,
    input  logic pre_all_i,
    input  logic wr_any_i,
    input  logic auto_pre_i,
    output logic open_o,
    output logic wpb_o
);
    bank_state_e state_q, state_d;
    logic        close_req;

    assign close_req = pre_all_i || (sel_i && pre_i) || (sel_i && wr_any_i && auto_pre_i);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (sel_i && act_i) state_d = act_wpb_i ? BK_OPEN_WPB : BK_OPEN;
            end
            BK_OPEN, BK_OPEN_WPB: begin
                if (close_req) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    always_comb begin
        open_o = 1'b0;
        wpb_o  = 1'b0;
        unique case (state_q)
            BK_IDLE:     ;
            BK_OPEN:     open_o = 1'b1;
            BK_OPEN_WPB: begin open_o = 1'b1; wpb_o = 1'b1; end
            default:     ;
        endcase
    end
endmodule

// File: rtl/gwm_mask_regs.sv
module gwm_mask_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              ld_sel_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] colour_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '1;
            colour_o <= '0;
        end else if (ld_i) begin
            if (ld_sel_i) colour_o <= dq_i;
            else          mask_o   <= dq_i;
        end
    end
endmodule

// File: rtl/gwm_merge.sv
module gwm_merge #(
    parameter int DATA_W   = 32,
    parameter int COL_W    = 8,
    parameter int BLK_COLS = 8,
    parameter int BANK_W   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  bw_i,
    input  logic [BANK_W-1:0]     bank_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [DATA_W-1:0]     dq_i,
    input  logic [DATA_W/8-1:0]   dqm_i,
    input  logic                  bank_open_i,
    input  logic                  bank_wpb_i,
    input  logic [DATA_W-1:0]     mask_i,
    input  logic [DATA_W-1:0]     colour_i,
    output logic                  we_o,
    output logic [BANK_W-1:0]     we_bank_o,
    output logic [COL_W-1:0]      we_col_o,
    output logic [BLK_COLS-1:0]   col_en_o,
    output logic [DATA_W-1:0]     bit_en_o,
    output logic [DATA_W-1:0]     data_o
);
    localparam int BYTES = DATA_W / 8;
    localparam int SEL_W = $clog2(BLK_COLS);

    logic [DATA_W-1:0]   lane_en, wpb_en;
    logic [BLK_COLS-1:0] col_sel;
    logic                fire;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_en[b*8 +: 8] = {8{~dqm_i[b]}};
    end

    assign wpb_en  = bank_wpb_i ? mask_i : '1;
    assign fire    = (wr_i || bw_i) && bank_open_i;
    assign col_sel = bw_i ? dq_i[BLK_COLS-1:0] : (BLK_COLS'(1) << col_i[SEL_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            we_o      <= 1'b0;
            we_bank_o <= '0;
            we_col_o  <= '0;
            col_en_o  <= '0;
            bit_en_o  <= '0;
            data_o    <= '0;
        end else begin
            we_o      <= 1'b1;
            we_bank_o <= bank_i;
            we_col_o  <= {col_i[COL_W-1:SEL_W], SEL_W'(0)};
            col_en_o  <= col_sel;
            bit_en_o  <= lane_en & wpb_en;
            data_o    <= bw_i ? colour_i : dq_i;
        end
    end
endmodule

// File: rtl/gram_wmask_unit.sv
module gram_wmask_unit #(
    parameter int DATA_W    = 32,
    parameter int COL_W     = 8,
    parameter int BLK_COLS  = 8,
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_i,
    input  logic                  act_wpb_i,
    input  logic                  pre_i,
    input  logic                  pre_all_i,
    input  logic                  wr_i,
    input  logic                  bw_i,
    input  logic                  auto_pre_i,
    input  logic                  ld_i,
    input  logic                  ld_sel_i,
    input  logic [BANK_W-1:0]     bank_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [DATA_W-1:0]     dq_i,
    input  logic [DATA_W/8-1:0]   dqm_i,
    output logic                  we_o,
    output logic [BANK_W-1:0]     we_bank_o,
    output logic [COL_W-1:0]      we_col_o,
    output logic [BLK_COLS-1:0]   col_en_o,
    output logic [DATA_W-1:0]     bit_en_o,
    output logic [DATA_W-1:0]     data_o
);
    logic [NUM_BANKS-1:0] bank_open, bank_wpb;
    logic [DATA_W-1:0]    mask_q, colour_q;
    logic                 wr_any;

    assign wr_any = wr_i || bw_i;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        gwm_bank_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (bank_i == BANK_W'(g)),
            .act_i      (act_i),
            .act_wpb_i  (act_wpb_i),
            .pre_i      (pre_i),
            .pre_all_i  (pre_all_i),
            .wr_any_i   (wr_any),
            .auto_pre_i (auto_pre_i),
            .open_o     (bank_open[g]),
            .wpb_o      (bank_wpb[g])
        );
    end

    gwm_mask_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (ld_i),
        .ld_sel_i (ld_sel_i),
        .dq_i     (dq_i),
        .mask_o   (mask_q),
        .colour_o (colour_q)
    );

    gwm_merge #(
        .DATA_W(DATA_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS), .BANK_W(BANK_W)
    ) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_i),
        .bw_i        (bw_i),
        .bank_i      (bank_i),
        .col_i       (col_i),
        .dq_i        (dq_i),
        .dqm_i       (dqm_i),
        .bank_open_i (bank_open[bank_i]),
        .bank_wpb_i  (bank_wpb[bank_i]),
        .mask_i      (mask_q),
        .colour_i    (colour_q),
        .we_o        (we_o),
        .we_bank_o   (we_bank_o),
        .we_col_o    (we_col_o),
        .col_en_o    (col_en_o),
        .bit_en_o    (bit_en_o),
        .data_o      (data_o)
    );
endmodule

// File: rtl/gwm_checker.sv
module gwm_checker #(
    parameter int DATA_W    = 32,
    parameter int BLK_COLS  = 8,
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    parameter int SEL_W     = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_i,
    input logic                  bw_i,
    input logic                  pre_all_i,
    input logic                  auto_pre_i,
    input logic [BANK_W-1:0]     bank_i,
    input logic [DATA_W-1:0]     dq_i,
    input logic [DATA_W/8-1:0]   dqm_i,
    input logic                  we_o,
    input logic [SEL_W-1:0]      col_lo,
    input logic [BLK_COLS-1:0]   col_en_o,
    input logic [DATA_W-1:0]     bit_en_o,
    input logic [DATA_W-1:0]     data_o,
    input logic [NUM_BANKS-1:0]  bank_open,
    input logic [NUM_BANKS-1:0]  bank_wpb,
    input logic [DATA_W-1:0]     mask_q,
    input logic [DATA_W-1:0]     colour_q
);
    localparam int BYTES = DATA_W / 8;

    function automatic logic [DATA_W-1:0] lanes(input logic [BYTES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BYTES; b++) r[b*8 +: 8] = {8{~m[b]}};
        return r;
    endfunction

    AST_QUIET_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_o |-> (bit_en_o == '0 && col_en_o == '0 && data_o == '0)); // R1
    AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && bank_open[bank_i] |=> $countones(col_en_o) == 1 && data_o == $past(dq_i)); // R2
    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || bw_i) && bank_open[bank_i] |=> (bit_en_o & ~lanes($past(dqm_i))) == '0); // R3
    AST_PLAIN_ROW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && bank_open[bank_i] && !bank_wpb[bank_i] |=> bit_en_o == lanes($past(dqm_i))); // R4
    AST_WPB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || bw_i) && bank_wpb[bank_i] |=> (bit_en_o & ~$past(mask_q)) == '0); // R5
    AST_BLOCK_COLS: assert property (@(posedge clk) disable iff (!rst_n)
        bw_i && bank_open[bank_i] |=> col_en_o == $past(dq_i[BLK_COLS-1:0]) && data_o == $past(colour_q)); // R7
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> col_lo == '0); // R7
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_i |=> bank_open == '0); // R8
    AST_AUTO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || bw_i) && auto_pre_i && bank_open[bank_i] |=> we_o && !bank_open[$past(bank_i)]); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || bw_i) && !bank_open[bank_i] |=> !we_o); // R10
endmodule

bind gram_wmask_unit gwm_checker #(
    .DATA_W(DATA_W), .BLK_COLS(BLK_COLS), .NUM_BANKS(NUM_BANKS),
    .BANK_W(BANK_W), .SEL_W($clog2(BLK_COLS))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_i),
    .bw_i       (bw_i),
    .pre_all_i  (pre_all_i),
    .auto_pre_i (auto_pre_i),
    .bank_i     (bank_i),
    .dq_i       (dq_i),
    .dqm_i      (dqm_i),
    .we_o       (we_o),
    .col_lo     (we_col_o[$clog2(BLK_COLS)-1:0]),
    .col_en_o   (col_en_o),
    .bit_en_o   (bit_en_o),
    .data_o     (data_o),
    .bank_open  (bank_open),
    .bank_wpb   (bank_wpb),
    .mask_q     (mask_q),
    .colour_q   (colour_q)
);

// File: tb/gram_wmask_unit_tb_top.sv
module gram_wmask_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic act_i = 0, act_wpb_i = 0, pre_i = 0, pre_all_i = 0, wr_i = 0, bw_i = 0;
    logic auto_pre_i = 0, ld_i = 0, ld_sel_i = 0;
    logic [0:0]  bank_i = '0;
    logic [7:0]  col_i = '0;
    logic [31:0] dq_i = '0;
    logic [3:0]  dqm_i = '0;
    logic        we_o;
    logic [0:0]  we_bank_o;
    logic [7:0]  we_col_o, col_en_o;
    logic [31:0] bit_en_o, data_o;

    gram_wmask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .act_i(act_i), .act_wpb_i(act_wpb_i), .pre_i(pre_i),
        .pre_all_i(pre_all_i), .wr_i(wr_i), .bw_i(bw_i), .auto_pre_i(auto_pre_i),
        .ld_i(ld_i), .ld_sel_i(ld_sel_i), .bank_i(bank_i), .col_i(col_i), .dq_i(dq_i),
        .dqm_i(dqm_i), .we_o(we_o), .we_bank_o(we_bank_o), .we_col_o(we_col_o),
        .col_en_o(col_en_o), .bit_en_o(bit_en_o), .data_o(data_o)
    );

    typedef enum {C_NOP, C_ACT, C_ACTW, C_PRE, C_PREALL, C_WR, C_BW, C_LDM, C_LDC} cmd_e;
    typedef struct packed {
        logic        we;
        logic [0:0]  bank;
        logic [7:0]  col;
        logic [7:0]  cen;
        logic [31:0] ben;
        logic [31:0] data;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0, fails = 0;
    bit    done = 0;

    bit          m_open[2];
    bit          m_wpb[2];
    logic [31:0] m_mask = '1, m_colour = '0;

    function automatic obs_t observe();
        return {we_o, we_bank_o, we_col_o, col_en_o, bit_en_o, data_o};
    endfunction

    task automatic check(input string tag, input obs_t act, input obs_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual we=%0b bank=%0d col=%02h cen=%02h ben=%08h data=%08h expected we=%0b bank=%0d col=%02h cen=%02h ben=%08h data=%08h",
                     tag, act.we, act.bank, act.col, act.cen, act.ben, act.data,
                     exp.we, exp.bank, exp.col, exp.cen, exp.ben, exp.data);
        end
    endtask

    task automatic issue(input string tag, input cmd_e c, input int bk, input bit ap,
                         input logic [7:0] col, input logic [31:0] dq, input logic [3:0] dqm);
        obs_t        e;
        logic [31:0] ln;
        @(negedge clk);
        act_i = (c == C_ACT || c == C_ACTW); act_wpb_i = (c == C_ACTW);
        pre_i = (c == C_PRE); pre_all_i = (c == C_PREALL);
        wr_i = (c == C_WR); bw_i = (c == C_BW); auto_pre_i = ap;
        ld_i = (c == C_LDM || c == C_LDC); ld_sel_i = (c == C_LDC);
        bank_i = (bk != 0); col_i = col; dq_i = dq; dqm_i = dqm;
        e = '0;
        if ((c == C_WR || c == C_BW) && m_open[bk]) begin
            for (int b = 0; b < 4; b++) ln[b*8 +: 8] = {8{~dqm[b]}};
            e.we   = 1'b1;
            e.bank = (bk != 0);
            e.col  = {col[7:3], 3'b000};
            e.cen  = (c == C_BW) ? dq[7:0] : (8'b1 << col[2:0]);
            e.ben  = ln & (m_wpb[bk] ? m_mask : 32'hFFFF_FFFF);
            e.data = (c == C_BW) ? m_colour : dq;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        case (c)
            C_ACT, C_ACTW: if (!m_open[bk]) begin m_open[bk] = 1; m_wpb[bk] = (c == C_ACTW); end
            C_PRE:    begin m_open[bk] = 0; m_wpb[bk] = 0; end
            C_PREALL: for (int i = 0; i < 2; i++) begin m_open[i] = 0; m_wpb[i] = 0; end
            C_WR, C_BW: if (ap && m_open[bk]) begin m_open[bk] = 0; m_wpb[bk] = 0; end
            C_LDM:    m_mask = dq;
            C_LDC:    m_colour = dq;
            default:  ;
        endcase
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), observe(), exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", observe(), '0);
        rst_n = 1'b1;
        issue("R1 idle after reset", C_NOP, 0, 0, 8'h00, 32'h0, 4'h0);
        issue("R10 write idle bank0", C_WR, 0, 0, 8'h05, 32'hDEAD_BEEF, 4'h0);
        issue("R10 block idle bank1", C_BW, 1, 0, 8'h10, 32'h0000_00FF, 4'h0);
        issue("R4 plain act bank0", C_ACT, 0, 0, 8'h00, 32'h0, 4'h0);
        issue("R2 write bank0", C_WR, 0, 0, 8'h13, 32'hA5A5_5A5A, 4'h0);
        issue("R3 byte masks 0101", C_WR, 0, 0, 8'h27, 32'h1122_3344, 4'b0101);
        issue("R5 wpb act bank1", C_ACTW, 1, 0, 8'h00, 32'h0, 4'h0);
        issue("R1 mask reset all ones", C_WR, 1, 0, 8'h01, 32'h5555_AAAA, 4'h0);
        issue("R6 load mask", C_LDM, 0, 0, 8'h00, 32'h0F0F_F0F0, 4'h0);
        issue("R6 load colour", C_LDC, 0, 0, 8'h00, 32'h1234_5678, 4'h0);
        issue("R5 masked write bank1", C_WR, 1, 0, 8'h32, 32'hFFFF_FFFF, 4'h0);
        issue("R3 R5 byte and bit mask", C_WR, 1, 0, 8'h33, 32'hCAFE_F00D, 4'b1000);
        issue("R7 block write bank1", C_BW, 1, 0, 8'h45, 32'h0000_00A3, 4'h0);
        issue("R3 block write byte mask", C_BW, 1, 0, 8'h47, 32'h0000_0081, 4'b0010);
        issue("R4 R11 plain bank0 unmasked", C_WR, 0, 0, 8'h08, 32'h0BAD_CAFE, 4'h0);
        issue("R10 act on open bank1", C_ACT, 1, 0, 8'h00, 32'h0, 4'h0);
        issue("R10 bank1 keeps wpb", C_WR, 1, 0, 8'h50, 32'h7777_7777, 4'h0);
        issue("R8 precharge bank1", C_PRE, 1, 0, 8'h00, 32'h0, 4'h0);
        issue("R8 write closed bank1", C_WR, 1, 0, 8'h50, 32'h7777_7777, 4'h0);
        issue("R11 bank0 still open", C_WR, 0, 0, 8'h09, 32'h2468_ACE0, 4'h0);
        issue("R8 reopen bank1 plain", C_ACT, 1, 0, 8'h00, 32'h0, 4'h0);
        issue("R8 wpb cleared bank1", C_WR, 1, 0, 8'h61, 32'h1357_9BDF, 4'h0);
        issue("R9 write auto close bank0", C_WR, 0, 1, 8'h0A, 32'h3333_4444, 4'h0);
        issue("R9 bank0 closed", C_WR, 0, 0, 8'h0A, 32'h3333_4444, 4'h0);
        issue("R6 new colour", C_LDC, 0, 0, 8'h00, 32'h00C0_FFEE, 4'h0);
        issue("R7 R9 block auto close", C_BW, 1, 1, 8'hF7, 32'h0000_003C, 4'h0);
        issue("R9 bank1 closed", C_BW, 1, 0, 8'hF0, 32'h0000_00FF, 4'h0);
        issue("R11 wpb act bank0", C_ACTW, 0, 0, 8'h00, 32'h0, 4'h0);
        issue("R11 plain act bank1", C_ACT, 1, 0, 8'h00, 32'h0, 4'h0);
        issue("R11 bank0 masked", C_WR, 0, 0, 8'h1E, 32'hFFFF_FFFF, 4'h0);
        issue("R11 bank1 unmasked", C_WR, 1, 0, 8'h1F, 32'hFFFF_FFFF, 4'h0);
        issue("R8 precharge all", C_PREALL, 0, 0, 8'h00, 32'h0, 4'h0);
        issue("R8 bank0 closed", C_WR, 0, 0, 8'h00, 32'h1, 4'h0);
        issue("R8 bank1 closed", C_BW, 1, 0, 8'h00, 32'hFF, 4'h0);
        issue("R1 quiet tail", C_NOP, 0, 0, 8'h00, 32'h0, 4'h0);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule